// File: doc/BRIEF.md
# Programmable IR Carrier Generator

This block makes the modulation carrier for an infrared transmitter. A 5-bit frequency code picks one of 32 carrier rates between 30 kHz and 60 kHz. Each carrier cycle is a fixed-length high time followed by a low time that fills out the period. The period, counted in cycles of the block clock (24 MHz by default), is taken from a table that elaboration fills with round(CLK_HZ / f) for every code. The single carrier output goes to a transmit sequencer, which gates it.

The mapping from code to frequency is not linear. Codes 3 to 29 give (code + 27) kHz. Code 30 gives 56.9 kHz. Codes 0, 1 and 2 wrap around to 58, 59 and 60 kHz. The one code left over, 31, falls back to the 36 kHz default. The high time is `HIGH_CYC` clock cycles (168, which is 7 µs at 24 MHz). If a period is shorter than twice that, the high time drops to half the period, rounded down.

The host writes the code through a plain one-cycle write strobe. No data stream flows through the block, so it has no valid/ready handshake and never applies back-pressure. A write that lands mid-period is held until the current carrier cycle ends. A write made while the generator is disabled is applied straight away. The enable input holds the output low and restarts the phase.

Top module: `ircar_gen`

## Requirements
- R1: After reset the carrier output is low and the active code is 9, so the first enable with no prior write produces a 36 kHz carrier.
- R2: For codes 3 to 29 the carrier frequency is (code + 27) kHz, and the period is round(CLK_HZ / f) clock cycles.
- R3: Code 30 selects 56.9 kHz, so the period is round(CLK_HZ / 56900) cycles.
- R4: Codes 0, 1 and 2 select 58, 59 and 60 kHz respectively.
- R5: Code 31 selects 36 kHz.
- R6: Each carrier cycle is high for HIGH_CYC clock cycles and then low for the rest of the period. If the period is shorter than 2*HIGH_CYC, the high time is floor(period / 2).
- R7: A code written with `cfg_we` while the carrier runs takes effect at the next period boundary, and the period in progress finishes with the old timing. When several writes fall within one period, the last one wins.
- R8: The carrier is low from the first clock edge at which `en` is sampled low, and it stays low while `en` stays low. A code written while disabled is applied within two clock edges, before the next enable.
- R9: When `en` is first sampled high, the carrier goes high on that same edge and begins a full high phase of a fresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (CLK_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the carrier; low forces the output low and restarts the phase |
| cfg_we | input | 1 | One-cycle write strobe for the frequency code |
| cfg_code | input | 5 | Frequency code written on `cfg_we` |
| carrier | output | 1 | Registered carrier waveform |

## Verification
The bench builds the block with CLK_HZ = 2,400,000 and HIGH_CYC = 30. This scales every period down to between 40 and 80 cycles, so each code can be measured edge to edge within a short run. The same values move the clamp threshold to 60 cycles, which means codes above 40 kHz run with a halved high time and codes below it keep the fixed high time, so both branches of R6 are exercised. Writes are placed exactly at a carrier rise and one cycle later, which tests boundary deferral and last-write-wins against known phase positions.

// File: rtl/ircar_pkg.sv
package ircar_pkg;
  localparam int CODE_W   = 5;
  localparam int NCODE    = 1 << CODE_W;
  localparam logic [CODE_W-1:0] RST_CODE = 5'd9;  // 36 kHz
  localparam int LOW_HZ   = 30000;

  // Carrier frequency in Hz selected by a code
  function automatic int code_hz(int code);
    if (code <= 2)       return 58000 + code * 1000;
    else if (code == 30) return 56900;
    else if (code >= 31) return 36000;
    else                 return (code + 27) * 1000;
  endfunction

  // Rounded number of clock cycles in one carrier period
  function automatic int hz_to_cyc(int clk_hz, int hz);
    return (clk_hz + hz / 2) / hz;
  endfunction
endpackage

// File: rtl/ircar_lut.sv
module ircar_lut #(
  parameter int CLK_HZ   = 24_000_000,
  parameter int HIGH_CYC = 168,
  parameter int PW       = 10
) (
  input  logic [ircar_pkg::CODE_W-1:0] code,
  output logic [PW-1:0]                period,
  output logic [PW-1:0]                high
);
  logic [PW-1:0] per_tab [ircar_pkg::NCODE];
  logic [PW-1:0] hi_tab  [ircar_pkg::NCODE];

  for (genvar g = 0; g < ircar_pkg::NCODE; g++) begin : g_entry
    localparam int P  = ircar_pkg::hz_to_cyc(CLK_HZ, ircar_pkg::code_hz(g));
    localparam int HI = (P < 2 * HIGH_CYC) ? P / 2 : HIGH_CYC;
    assign per_tab[g] = PW'(P);
    assign hi_tab[g]  = PW'(HI);
  end

  always_comb begin
    period = per_tab[code];
    high   = hi_tab[code];
  end
endmodule

// File: rtl/ircar_cfg.sv
module ircar_cfg (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ircar_pkg::CODE_W-1:0]  code_in,
  input  logic                          en,
  input  logic                          wrap,
  output logic [ircar_pkg::CODE_W-1:0]  active_code
);
  logic [ircar_pkg::CODE_W-1:0] pend_code;
  logic                         pend_vld;
  logic                         apply;

  assign apply = !en || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_code <= ircar_pkg::RST_CODE;
      pend_code   <= ircar_pkg::RST_CODE;
      pend_vld    <= 1'b0;
    end else begin
      if (apply && pend_vld) begin
        active_code <= pend_code;
        pend_vld    <= 1'b0;
      end
      if (we) begin
        pend_code <= code_in;
        pend_vld  <= 1'b1;
      end
    end
  end

  // R7
  apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && apply) |=> (active_code == $past(pend_code)));
endmodule

// File: rtl/ircar_phase.sv
module ircar_phase #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period,
  input  logic [PW-1:0] high,
  output logic          wrap,
  output logic          carrier
);
  logic [PW-1:0] cnt;

  assign wrap = en && (cnt == period - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt     <= '0;
      carrier <= 1'b0;
    end else begin
      carrier <= (cnt < high);
      cnt     <= wrap ? '0 : cnt + PW'(1);
    end
  end

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !carrier);

  // R9
  rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> (cnt == PW'(1)));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < period));
endmodule

// File: rtl/ircar_gen.sv
module ircar_gen #(
  parameter int CLK_HZ   = 24_000_000,
  parameter int HIGH_CYC = 168
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cfg_we,
  input  logic [4:0] cfg_code,
  output logic       carrier
);
  localparam int PMAX = ircar_pkg::hz_to_cyc(CLK_HZ, ircar_pkg::LOW_HZ);
  localparam int PW   = $clog2(PMAX + 1);

  logic [ircar_pkg::CODE_W-1:0] active_code;
  logic [PW-1:0]                period;
  logic [PW-1:0]                high;
  logic                         wrap;

  ircar_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .code_in     (cfg_code),
    .en          (en),
    .wrap        (wrap),
    .active_code (active_code)
  );

  ircar_lut #(.CLK_HZ(CLK_HZ), .HIGH_CYC(HIGH_CYC), .PW(PW)) u_lut (
    .code   (active_code),
    .period (period),
    .high   (high)
  );

  ircar_phase #(.PW(PW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .period  (period),
    .high    (high),
    .wrap    (wrap),
    .carrier (carrier)
  );

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(active_code));
endmodule

// File: tb/ircar_gen_test.sv
module ircar_gen_test;
  localparam int CLK_HZ = 2_400_000;
  localparam int HIGH   = 30;

  logic clk = 1'b0;
  logic rst_n, en, cfg_we;
  logic [4:0] cfg_code;
  logic carrier;
  logic car;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  ircar_gen #(.CLK_HZ(CLK_HZ), .HIGH_CYC(HIGH)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
    .cfg_code(cfg_code), .carrier(carrier)
  );

  always #2.5 clk = ~clk;

  function automatic int ehz(int c);
    case (c)
      0: return 58000;
      1: return 59000;
      2: return 60000;
      30: return 56900;
      31: return 36000;
      default: return (c + 27) * 1000;
    endcase
  endfunction
  function automatic int eper(int c);
    return (CLK_HZ + ehz(c) / 2) / ehz(c);
  endfunction
  function automatic int ehi(int c);
    return (eper(c) < 2 * HIGH) ? eper(c) / 2 : HIGH;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cfg_we = 1'b0;
    car = carrier;
  endtask

  // Starts at the first high sample; ends at the next one
  task automatic measure(input int hi0, output int hi, output int lo);
    hi = hi0; lo = 0;
    for (int n = 0; n < 1000; n++) begin
      tick();
      if (!car) break;
      hi++;
    end
    lo = 1;
    for (int n = 0; n < 1000; n++) begin
      tick();
      if (car) break;
      lo++;
    end
  endtask

  task automatic check_code(string req, int code, int hi, int lo);
    check({req, " high"}, hi, ehi(code));
    check({req, " period"}, hi + lo, eper(code));
  endtask

  task automatic write_off(int code);
    cfg_code = 5'(code); cfg_we = 1'b1;
    tick(); tick(); tick();
  endtask

  // Enable from off, check restart and two periods
  task automatic run_code(string req, int code);
    int hi, lo;
    en = 1'b1;
    tick();
    check("R9 first high", int'(car), 1);
    measure(1, hi, lo);
    check_code(req, code, hi, lo);
    measure(1, hi, lo);
    check_code(req, code, hi, lo);
  endtask

  task automatic stop_run();
    en = 1'b0;
    tick();
    check("R8 low after disable", int'(car), 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8 stays low", int'(car), 0);
    end
  endtask

  initial begin
    int hi, lo, cur, a, b;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; en = 1'b0; cfg_we = 1'b0; cfg_code = '0;
    repeat (4) tick();
    check("R1 low in reset", int'(car), 0);
    rst_n = 1'b1;
    tick(); tick();
    check("R1 low after reset", int'(car), 0);

    // R1: default code
    run_code("R1 default 36k", 9);
    stop_run();

    // R2..R6 directed codes
    write_off(3);  run_code("R2 code 3", 3);   stop_run();
    write_off(29); run_code("R2 code 29", 29); stop_run();
    write_off(30); run_code("R3 code 30", 30); stop_run();
    write_off(0);  run_code("R4 code 0", 0);   stop_run();
    write_off(1);  run_code("R4 code 1", 1);   stop_run();
    write_off(2);  run_code("R4 code 2", 2);   stop_run();
    write_off(31); run_code("R5 code 31", 31); stop_run();
    write_off(20); run_code("R6 clamped code 20", 20);
    cur = 20;

    // R7: write mid-period at a rise
    cfg_code = 5'd5; cfg_we = 1'b1;
    measure(1, hi, lo);
    check_code("R7 old period kept", cur, hi, lo);
    measure(1, hi, lo);
    check_code("R7 new code applied", 5, hi, lo);
    cur = 5;

    // R7: last write in a period wins
    cfg_code = 5'd0; cfg_we = 1'b1;
    tick();
    cfg_code = 5'd11; cfg_we = 1'b1;
    measure(2, hi, lo);
    check_code("R7 old period kept", cur, hi, lo);
    measure(1, hi, lo);
    check_code("R7 last write wins", 11, hi, lo);
    cur = 11;

    // R8/R9: disable in high phase, restart with full high
    stop_run();
    run_code("R9 restart", cur);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      b = int'($urandom % 32);
      if ($urandom % 2 == 0) begin
        a = cur;
        cfg_code = 5'(b); cfg_we = 1'b1;
        measure(1, hi, lo);
        check_code("R7 random old", a, hi, lo);
        measure(1, hi, lo);
        check_code("R2 random new", b, hi, lo);
      end else begin
        stop_run();
        write_off(b);
        run_code("R8 random off write", b);
      end
      cur = b;
    end

    summary();
    $finish;
  end
endmodule